// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block holds the transfer count for the DMA side of a SCSI bus controller. The host programs a 24-bit start count one byte at a time, through three byte-wide register addresses. The running count is separate. It is loaded from the start count only when the host issues a command that has its DMA bit set. After that, the DMA engine decrements it by the number of bytes each transfer strobe moved.

When the running count reaches zero from a nonzero value, a sticky status flag is raised. A host write to any count register clears that flag. A combinational count-zero output tells the DMA engine to stop requesting data.

Reads at the three count addresses return bytes of the running count, not of the start count. The most significant address is an exception until it is first written after reset: until then it returns a fixed identification byte, so that software can recognise the controller.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset the start count, the running count, the status flag and the high-byte-written marker are all zero. Reads at address 0 and 1 return 0x00, `tc_flag` is 0 and `count_zero` is 1.
- R2: Reads return the running count one byte at a time. Address 0 gives bits 7:0, address 1 gives bits 15:8 and address 2 gives bits 23:16. Address 3 reads 0x00.
- R3: A register write at address 0, 1 or 2 updates only the matching byte of the start count. The running count does not change until the next load.
- R4: A command pulse with `cmd_dma`=1 loads the running count from the start count at the next clock edge. A command pulse with `cmd_dma`=0 leaves the running count unchanged.
- R5: A load with a start count of zero puts 0x010000 into the running count.
- R6: A decrement strobe lowers the running count by `dec_amount` (1 to 16 bytes). If the amount is larger than the count, the count saturates at zero and does not wrap.
- R7: `tc_flag` is set only when an update takes the running count from a nonzero value to zero. A decrement while the count is already zero leaves the flag unchanged.
- R8: A write at address 0, 1 or 2 clears `tc_flag`. A write at address 3 is ignored.
- R9: Until address 2 has been written once after reset, reads at address 2 return the identification byte `CHIP_ID` (default 0xA2).
- R10: `count_zero` is 1 exactly when the running count is zero.
- R11: When a DMA load and a decrement strobe arrive in the same cycle, the load wins and the decrement is dropped.
- R12: When a count-register write and a zero-reaching decrement arrive in the same cycle, `tc_flag` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| cmd_issue | input | 1 | One-cycle command strobe |
| cmd_dma | input | 1 | DMA bit of the issued command |
| dec_valid | input | 1 | Transfer strobe |
| dec_amount | input | 5 | Bytes moved by the strobe, 1 to 16 |
| count_zero | output | 1 | Running count is zero |
| tc_flag | output | 1 | Sticky status flag for a nonzero-to-zero change |

## Verification
Two pairs of functions can fall into the same clock cycle.

The first pair is the status flag. A host write that clears it can land in the same cycle as the transfer strobe that brings the count to zero. The bench raises the register write and the final decrement in one cycle, then requires the flag to read as set.

The second pair is the load path. A DMA command load can meet a decrement in the same cycle. The bench issues both at once and compares the read-back count with the start value, unreduced.

// File: rtl/dtc_pkg.sv
// Package: shared types for the DMA transfer byte counter.
// Assumes: a single clock domain; the update kinds are mutually exclusive per cycle.
package dtc_pkg;

    // Which update the running count takes in a given cycle.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_DEC  = 2'd2
    } tc_upd_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/dtc_start_regs.sv
// Module: dtc_start_regs
// Holds the host-programmed start count as byte lanes and the marker that
// records the first write to the most significant lane.
// Assumes: the address picks a lane directly; addresses at or above
// CNT_BYTES hit nothing.
module dtc_start_regs #(
    parameter int CNT_BYTES = 3,
    parameter int CNT_W     = 8 * CNT_BYTES,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  start_cnt,
    output logic              hi_written,
    output logic              count_wr
);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CNT_BYTES - 1);

    // Decode a write that targets any count lane.
    assign count_wr = wr_en && (wr_addr < ADDR_W'(CNT_BYTES));

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
        logic [7:0] lane_q;
        // Capture host data into this lane of the start count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(b))
                lane_q <= wr_data;
        end
        assign start_cnt[b*8 +: 8] = lane_q;
    end

    // Remember that the top lane has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_written <= 1'b0;
        else if (wr_en && wr_addr == HI_ADDR)
            hi_written <= 1'b1;
    end

    // R9: the marker never falls back without a reset.
    p_marker_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_written |=> hi_written);

    // R3: a lane changes only on a write addressed to it.
    p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(start_cnt));

endmodule

// File: rtl/dtc_count_core.sv
// Module: dtc_count_core
// Running transfer count with reload, saturating decrement and the sticky
// nonzero-to-zero status flag.
// Assumes: load_req has priority over dec_req; a flag set event has priority
// over a clear in the same cycle.
module dtc_count_core
    import dtc_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              dec_req,
    input  logic [STEP_W-1:0] dec_amt,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              status_clr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              zero_flag
);
    localparam logic [CNT_W-1:0] ZERO_RELOAD = CNT_W'(32'h0001_0000);

    tc_upd_e          upd;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] amt_ext;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] cnt_next;
    logic             hit_zero;

    // Pick the single update that applies this cycle.
    always_comb begin
        if (load_req)     upd = UPD_LOAD;
        else if (dec_req) upd = UPD_DEC;
        else              upd = UPD_NONE;
    end

    // Form the reload value and the saturated decrement result.
    always_comb begin
        load_val = (start_cnt == '0) ? ZERO_RELOAD : start_cnt;
        amt_ext  = CNT_W'(dec_amt);
        dec_val  = (cur_cnt > amt_ext) ? (cur_cnt - amt_ext) : '0;
    end

    // Select the next count and detect a nonzero-to-zero change.
    always_comb begin
        case (upd)
            UPD_LOAD: cnt_next = load_val;
            UPD_DEC:  cnt_next = dec_val;
            default:  cnt_next = cur_cnt;
        endcase
        hit_zero = (cur_cnt != '0) && (cnt_next == '0);
    end

    // Register the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_cnt <= '0;
        else        cur_cnt <= cnt_next;
    end

    // Register the status flag: a set event wins over a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          zero_flag <= 1'b0;
        else if (hit_zero)   zero_flag <= 1'b1;
        else if (status_clr) zero_flag <= 1'b0;
    end

    // R4 and R5: a load puts the start value, or the zero reload, into the count.
    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> cur_cnt == (($past(start_cnt) == '0) ? ZERO_RELOAD : $past(start_cnt)));

    // R6: a decrement never makes the count grow.
    p_dec_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !load_req) |=> cur_cnt <= $past(cur_cnt));

    // R7: the flag rises only after a nonzero count became zero.
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> (cur_cnt == '0) && ($past(cur_cnt) != '0));

    // R8: a clear with no decrement leaves the flag low.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && (load_req || !dec_req)) |=> !zero_flag);

    // R3: with no update requested, the count holds.
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !dec_req) |=> $stable(cur_cnt));

endmodule

// File: rtl/dtc_read_mux.sv
// Module: dtc_read_mux
// Byte read selection of the running count, with the identification byte
// shown at the top address until that address has been written.
// Assumes: unmapped addresses read zero.
module dtc_read_mux #(
    parameter int         CNT_BYTES = 3,
    parameter int         CNT_W     = 8 * CNT_BYTES,
    parameter int         ADDR_W    = 2,
    parameter logic [7:0] CHIP_ID   = 8'hA2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              hi_written,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CNT_BYTES - 1);

    // Steer the addressed byte, overriding the top byte with the ID.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = cur_cnt[i*8 +: 8];
        end
        if (rd_addr == HI_ADDR && !hi_written)
            rd_data = CHIP_ID;
    end

endmodule

// File: rtl/dma_xfer_count.sv
// Module: dma_xfer_count
// Top of the DMA transfer byte counter: start-count registers, running count
// and read selection.
// Assumes: cmd_issue and dec_valid are single-cycle strobes in the clk domain.
module dma_xfer_count #(
    parameter int         CNT_BYTES = 3,
    parameter int         STEP_W    = 5,
    parameter logic [7:0] CHIP_ID   = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmd_issue,
    input  logic              cmd_dma,
    input  logic              dec_valid,
    input  logic [STEP_W-1:0] dec_amount,
    output logic              count_zero,
    output logic              tc_flag
);
    localparam int CNT_W  = 8 * CNT_BYTES;
    localparam int ADDR_W = 2;

    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] cur_cnt;
    logic             hi_written;
    logic             count_wr;
    logic             load_req;

    // A command reloads the count only when its DMA bit is set.
    assign load_req = cmd_issue && cmd_dma;

    dtc_start_regs #(
        .CNT_BYTES (CNT_BYTES),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .start_cnt  (start_cnt),
        .hi_written (hi_written),
        .count_wr   (count_wr)
    );

    dtc_count_core #(
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .dec_req    (dec_valid),
        .dec_amt    (dec_amount),
        .start_cnt  (start_cnt),
        .status_clr (count_wr),
        .cur_cnt    (cur_cnt),
        .zero_flag  (tc_flag)
    );

    dtc_read_mux #(
        .CNT_BYTES (CNT_BYTES),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .CHIP_ID   (CHIP_ID)
    ) u_rmux (
        .rd_addr    (reg_addr),
        .cur_cnt    (cur_cnt),
        .hi_written (hi_written),
        .rd_data    (reg_rdata)
    );

    // Expose the zero state to the DMA engine.
    assign count_zero = (cur_cnt == '0);

    // R11: a load in the same cycle as a decrement takes the start value.
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && dec_valid && start_cnt != '0) |=> cur_cnt == $past(start_cnt));

    // R12: a zero-reaching decrement beats a same-cycle register clear.
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && dec_valid && !load_req && cur_cnt != '0 &&
         cur_cnt <= CNT_W'(dec_amount)) |=> tc_flag);

endmodule

// File: tb/dma_xfer_count_test.sv
module dma_xfer_count_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] EXP_ID = 8'hA2;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_DMA = 2'd1;
    localparam logic [1:0] OP_DEC = 2'd2;
    localparam logic [1:0] OP_CMD = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [7:0]  arg;
        logic [23:0] exp_cnt;
        logic        exp_flag;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{OP_WR,  2'd2, 8'h00, 24'h000000, 1'b0, 4'd9},  // R9 high written
        '{OP_WR,  2'd0, 8'h05, 24'h000000, 1'b0, 4'd3},  // R3 no count change
        '{OP_DMA, 2'd0, 8'h00, 24'h000005, 1'b0, 4'd4},  // R4 load
        '{OP_DEC, 2'd0, 8'd3,  24'h000002, 1'b0, 4'd6},  // R6 decrement
        '{OP_DEC, 2'd0, 8'd4,  24'h000000, 1'b1, 4'd7},  // R7 saturate, flag set
        '{OP_WR,  2'd3, 8'hFF, 24'h000000, 1'b1, 4'd8},  // R8 unmapped ignored
        '{OP_WR,  2'd1, 8'h12, 24'h000000, 1'b0, 4'd8},  // R8 clear
        '{OP_DEC, 2'd0, 8'd1,  24'h000000, 1'b0, 4'd7},  // R7 zero to zero
        '{OP_CMD, 2'd0, 8'h00, 24'h000000, 1'b0, 4'd4},  // R4 non-DMA command
        '{OP_DMA, 2'd0, 8'h00, 24'h001205, 1'b0, 4'd4},  // R4 load
        '{OP_WR,  2'd0, 8'h00, 24'h001205, 1'b0, 4'd3},  // R3
        '{OP_WR,  2'd1, 8'h00, 24'h001205, 1'b0, 4'd3},  // R3
        '{OP_DMA, 2'd0, 8'h00, 24'h010000, 1'b0, 4'd5},  // R5 zero reload
        '{OP_DEC, 2'd0, 8'd16, 24'h00FFF0, 1'b0, 4'd6}   // R6 max step
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       cmd_issue;
    logic       cmd_dma;
    logic       dec_valid;
    logic [4:0] dec_amount;
    logic       count_zero;
    logic       tc_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_xfer_count uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cmd_issue  (cmd_issue),
        .cmd_dma    (cmd_dma),
        .dec_valid  (dec_valid),
        .dec_amount (dec_amount),
        .count_zero (count_zero),
        .tc_flag    (tc_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; cmd_issue = 1'b0; cmd_dma = 1'b0;
        dec_valid = 1'b0; dec_amount = '0; reg_wdata = '0;
    endtask

    // Apply one cycle of stimulus; outputs settle by the following negedge.
    task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d,
                        input bit cmd, input bit dma, input bit dec,
                        input logic [4:0] amt);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        cmd_issue = cmd; cmd_dma = dma; dec_valid = dec; dec_amount = amt;
        @(negedge clk);
        idle();
    endtask

    task automatic read_byte(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        read_byte(2'd0, b0);
        read_byte(2'd1, b1);
        read_byte(2'd2, b2);
        v = {b2, b1, b0};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rb;
        logic [23:0] cnt;
        rst_n = 1'b0;
        reg_addr = '0;
        idle();
        do_reset();

        // R1 reset state, R9 ID shown, R10 zero output
        read_byte(2'd0, rb); check(rb == 8'h00, "R1 low byte", rb, 0);
        read_byte(2'd1, rb); check(rb == 8'h00, "R1 mid byte", rb, 0);
        read_byte(2'd2, rb); check(rb == EXP_ID, "R9 ID after reset", rb, EXP_ID);
        check(tc_flag == 1'b0, "R1 flag", tc_flag, 0);
        check(count_zero == 1'b1, "R10 zero at reset", count_zero, 1);

        // R9: lower writes and a load do not unmask the top byte
        step(1, 2'd0, 8'h33, 0, 0, 0, 0);
        step(0, 2'd0, 8'h00, 1, 1, 0, 0);
        read_byte(2'd0, rb); check(rb == 8'h33, "R4 load low byte", rb, 8'h33);
        read_byte(2'd2, rb); check(rb == EXP_ID, "R9 ID before top write", rb, EXP_ID);
        check(count_zero == 1'b0, "R10 nonzero", count_zero, 0);
        do_reset();

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WR:  step(1, VEC[i].addr, VEC[i].arg, 0, 0, 0, 0);
                OP_DMA: step(0, 2'd0, 8'h00, 1, 1, 0, 0);
                OP_DEC: step(0, 2'd0, 8'h00, 0, 0, 1, VEC[i].arg[4:0]);
                default: step(0, 2'd0, 8'h00, 1, 0, 0, 0);
            endcase
            read_count(cnt);
            checks++;
            if (cnt !== VEC[i].exp_cnt || tc_flag !== VEC[i].exp_flag) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual cnt 0x%0h flag %0b expected cnt 0x%0h flag %0b",
                         VEC[i].req, i, cnt, tc_flag, VEC[i].exp_cnt, VEC[i].exp_flag);
            end
        end

        // R2 byte lanes of the running count
        step(1, 2'd0, 8'hEF, 0, 0, 0, 0);
        step(1, 2'd1, 8'hCD, 0, 0, 0, 0);
        step(1, 2'd2, 8'hAB, 0, 0, 0, 0);
        step(0, 2'd0, 8'h00, 1, 1, 0, 0);
        read_byte(2'd0, rb); check(rb == 8'hEF, "R2 byte 0", rb, 8'hEF);
        read_byte(2'd1, rb); check(rb == 8'hCD, "R2 byte 1", rb, 8'hCD);
        read_byte(2'd2, rb); check(rb == 8'hAB, "R2 byte 2", rb, 8'hAB);
        read_byte(2'd3, rb); check(rb == 8'h00, "R2 address 3", rb, 0);

        // R12: register write and zero-reaching decrement in one cycle
        step(1, 2'd1, 8'h00, 0, 0, 0, 0);
        step(1, 2'd2, 8'h00, 0, 0, 0, 0);
        step(1, 2'd0, 8'h01, 0, 0, 0, 0);
        step(0, 2'd0, 8'h00, 1, 1, 0, 0);
        step(1, 2'd0, 8'h09, 0, 0, 1, 5'd1);
        check(tc_flag == 1'b1, "R12 set beats clear", tc_flag, 1);
        read_count(cnt); check(cnt == 24'h0, "R12 count zero", cnt, 0);
        check(count_zero == 1'b1, "R10 zero after decrement", count_zero, 1);

        // R11: load and decrement in one cycle
        step(0, 2'd0, 8'h00, 1, 1, 1, 5'd5);
        read_count(cnt); check(cnt == 24'h000009, "R11 load wins", cnt, 24'h9);

        // R1: reset in mid-operation brings the ID back
        do_reset();
        read_byte(2'd2, rb); check(rb == EXP_ID, "R1 marker cleared", rb, EXP_ID);
        read_byte(2'd0, rb); check(rb == 8'h00, "R1 count cleared", rb, 0);
        check(tc_flag == 1'b0, "R1 flag cleared", tc_flag, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule